// File: doc/BRIEF.md
# Two-Character-Per-Clock Character-Class Automaton Matcher

The block scans a byte stream for a small regular pattern. The pattern is fixed at build time through parameter tables. Each pattern state has one flip-flop and a 256-bit membership mask that says which byte values may enter it. A per-state loop flag lets a state repeat. Because the automaton is nondeterministic, any number of states may be active at once. The entry state is armed again at every byte, so a match can start anywhere in the stream.

Each clock takes one beat of two bytes. The byte in bits [7:0] comes first in stream order. The state vector passes through two identical single-byte stages, one after the other, in the same cycle. The flag `match` and the per-lane indicator `match_lane` are registered, so several engines can be chained without a long output path. Bit k of `match_lane` says that the accepting state became active after lane k's byte.

The `in_sos` pulse restarts the stream. The `in_odd` flag marks a beat whose second byte is absent. The default pattern is `a[0-9]+b+`. State 0 takes 'a' (0x61). State 1 takes 0x30..0x39 and may repeat. State 2, the accepting state, takes 'b' (0x62) and may repeat.

Top module: `nfa_dual_matcher`

## Requirements
- R1: After reset, `match` and `match_lane` are 0. No pattern state is active, so a beat whose bytes cannot complete the pattern from scratch yields no match.
- R2: A match can start at any byte position of the stream, including in lane 1 of one beat with the pattern continuing into later beats.
- R3: The state for the `[0-9]` class is entered by any byte 0x30..0x39 and by no other byte. For example, 0x2F and 0x3A each break the pattern.
- R4: A state with its loop flag set stays active while its class keeps matching. The default pattern accepts one or more digits and one or more 'b' bytes.
- R5: Two bytes are consumed per valid beat. The byte in `in_data[7:0]` is processed before the byte in `in_data[15:8]`, and pattern state carries across beats.
- R6: In the output for a beat, `match_lane[0]` is 1 when the accepting state is active after the lane 0 byte. `match_lane[1]` is 1 when it is active after the lane 1 byte. Both bits may be 1. `match` is 1 exactly when `match_lane` is nonzero.
- R7: The outputs appear on the clock edge after the beat that produced them. In any cycle that follows a cycle with `in_valid` low, the outputs are 0.
- R8: While `in_valid` is low and `in_sos` is low, the state vector holds its value.
- R9: `in_sos` empties all pattern states. With `in_valid` low the state is simply cleared. With `in_valid` high the beat is processed from the emptied state.
- R10: When `in_odd` is high on a valid beat, the lane 1 byte is ignored. `match_lane[1]` is 0 and the state after the beat equals the state after lane 0 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat carries bytes |
| in_sos | input | 1 | Start of a new stream: clear pattern states |
| in_odd | input | 1 | Only the lane 0 byte of this beat is present |
| in_data | input | 16 | Lane 0 byte in [7:0], lane 1 byte in [15:8] |
| match | output | 1 | Accepting state reached in the previous beat |
| match_lane | output | 2 | Per-lane accept indicator for the previous beat |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- A match that spans beat boundaries, or that starts in lane 1. A design that resets the start state per beat, or swaps lane order, would miss it or report the wrong lane.
- Class edges 0x2F and 0x3A. An off-by-one mask would accept them.
- Both lanes accepting in one beat through the looping final state. A design that reports only one lane would show a wrong lane code.
- Idle beats, stream restarts with and without data, and odd-length beats. A design that lets idle cycles or the absent lane touch the state would match where the reference model does not, or fail to match where it does.

// File: rtl/nfa_pkg.sv
// Shared constants and the default pattern tables for the matcher.
// Assumes 8-bit characters; class masks are 256 bits, state i in slice i.
package nfa_pkg;
    localparam int CHAR_W  = 8;
    localparam int ALPHA_N = 1 << CHAR_W;

    // Build a membership mask covering the inclusive byte range lo..hi.
    function automatic logic [ALPHA_N-1:0] class_span(input int lo, input int hi);
        logic [ALPHA_N-1:0] m;
        for (int i = 0; i < ALPHA_N; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

    // Default pattern a[0-9]+b+ : state0 'a', state1 digits (loop), state2 'b' (loop).
    localparam int DEF_STATES = 3;
    localparam logic [DEF_STATES*ALPHA_N-1:0] DEF_CLASSES =
        {class_span(8'h62, 8'h62), class_span(8'h30, 8'h39), class_span(8'h61, 8'h61)};
    localparam logic [DEF_STATES-1:0] DEF_LOOPS = 3'b110;
endpackage

// File: rtl/nfa_char_step.sv
// One single-character transition stage of the automaton.
// State i turns on when the byte is in its class and either its predecessor
// (state i-1, or the always-armed entry for i == 0) or itself (loop flag) is on.
// When en is low the stage passes the vector through unchanged.
module nfa_char_step
    import nfa_pkg::*;
#(
    parameter int NSTATE = DEF_STATES,
    parameter logic [NSTATE*ALPHA_N-1:0] CLASSES = DEF_CLASSES,
    parameter logic [NSTATE-1:0] LOOPS = DEF_LOOPS
) (
    input  logic              en,
    input  logic [CHAR_W-1:0] ch,
    input  logic [NSTATE-1:0] cur,
    output logic [NSTATE-1:0] nxt
);
    genvar i;
    generate
        for (i = 0; i < NSTATE; i++) begin : g_state
            logic [ALPHA_N-1:0] cls;
            logic               hit;
            logic               entry;
            logic               keep;
            assign cls = CLASSES[i*ALPHA_N +: ALPHA_N];
            assign hit = cls[ch];
            if (i == 0) begin : g_first
                assign entry = 1'b1;
            end else begin : g_chain
                assign entry = cur[i-1];
            end
            assign keep = LOOPS[i] & cur[i];
            // Gate the stage: disabled lanes leave the state untouched.
            assign nxt[i] = en ? (hit & (entry | keep)) : cur[i];
        end
    endgenerate
endmodule

// File: rtl/nfa_state_reg.sv
// Holds the active-state vector. Loads on a valid beat, clears on a
// stream restart without data, otherwise keeps its value.
module nfa_state_reg #(
    parameter int NSTATE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic [NSTATE-1:0] d,
    output logic [NSTATE-1:0] q
);
    // State register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
        else if (clr)  q <= '0;
    end
endmodule

// File: rtl/nfa_match_reg.sv
// Registers the per-lane accept hits of a beat; outputs are zero after
// any cycle without a valid beat.
module nfa_match_reg #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LANES-1:0] hits,
    output logic             match,
    output logic [LANES-1:0] match_lane
);
    // Output register for match flag and lane indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match      <= 1'b0;
            match_lane <= '0;
        end else begin
            match      <= valid & (|hits);
            match_lane <= valid ? hits : '0;
        end
    end
endmodule

// File: rtl/nfa_dual_matcher.sv
// Top: multi-character NFA matcher. LANES identical character stages are
// chained combinationally each cycle; lane 0 is earliest in the stream.
// Assumes in_odd disables every lane above 0 for that beat.
module nfa_dual_matcher
    import nfa_pkg::*;
#(
    parameter int NSTATE = DEF_STATES,
    parameter int LANES  = 2,
    parameter logic [NSTATE*ALPHA_N-1:0] CLASSES = DEF_CLASSES,
    parameter logic [NSTATE-1:0] LOOPS = DEF_LOOPS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sos,
    input  logic                    in_odd,
    input  logic [LANES*CHAR_W-1:0] in_data,
    output logic                    match,
    output logic [LANES-1:0]        match_lane
);
    localparam int ACCEPT = NSTATE - 1;

    logic [NSTATE-1:0] state_q;
    logic [NSTATE-1:0] chain [LANES+1];
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  hits;

    // A restart with data processes the beat from an empty vector.
    assign chain[0] = in_sos ? '0 : state_q;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            if (k == 0) begin : g_l0
                assign lane_en[k] = 1'b1;
            end else begin : g_ln
                assign lane_en[k] = ~in_odd;
            end
            nfa_char_step #(
                .NSTATE (NSTATE),
                .CLASSES(CLASSES),
                .LOOPS  (LOOPS)
            ) u_step (
                .en (lane_en[k]),
                .ch (in_data[k*CHAR_W +: CHAR_W]),
                .cur(chain[k]),
                .nxt(chain[k+1])
            );
            assign hits[k] = lane_en[k] & chain[k+1][ACCEPT];
        end
    endgenerate

    nfa_state_reg #(.NSTATE(NSTATE)) u_state (
        .clk  (clk),
        .rst_n(rst_n),
        .load (in_valid),
        .clr  (in_sos),
        .d    (chain[LANES]),
        .q    (state_q)
    );

    nfa_match_reg #(.LANES(LANES)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (in_valid),
        .hits      (hits),
        .match     (match),
        .match_lane(match_lane)
    );
endmodule

// File: rtl/nfa_dual_matcher_chk.sv
// Checker for nfa_dual_matcher, attached by bind below.
module nfa_dual_matcher_chk #(
    parameter int NSTATE = 3,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sos,
    input logic              in_odd,
    input logic              match,
    input logic [LANES-1:0]  match_lane,
    input logic [NSTATE-1:0] state_q
);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!match && match_lane == '0));

    assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !in_sos) |=> $stable(state_q));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sos && !in_valid) |=> (state_q == '0));

    assert_odd_lane_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_odd) |=> !match_lane[LANES-1]);

    assert_flag_agrees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (match == (match_lane != '0)));
endmodule

bind nfa_dual_matcher nfa_dual_matcher_chk #(.NSTATE(NSTATE), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sos    (in_sos),
    .in_odd    (in_odd),
    .match     (match),
    .match_lane(match_lane),
    .state_q   (state_q)
);

// File: tb/sim_nfa_dual_matcher.sv
module sim_nfa_dual_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sos = 1'b0;
    logic        in_odd = 1'b0;
    logic [15:0] in_data = '0;
    logic        match;
    logic [1:0]  match_lane;

    int checks = 0;
    int fails  = 0;
    logic [2:0] ms = '0;   // reference: bit0 after 'a', bit1 in digits, bit2 in b's

    always #4 clk = ~clk;

    nfa_dual_matcher u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_odd(in_odd), .in_data(in_data), .match(match), .match_lane(match_lane)
    );

    function automatic logic [2:0] ref_step(input logic [2:0] s, input logic [7:0] c);
        logic [2:0] n;
        n[0] = (c == "a");
        n[1] = (c >= "0" && c <= "9") && (s[0] || s[1]);
        n[2] = (c == "b") && (s[1] || s[2]);
        return n;
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        checks++;
        if ({match, match_lane} !== exp) begin
            fails++;
            $display("FAIL %s: got match=%0b lane=%02b expected match=%0b lane=%02b",
                     tag, match, match_lane, exp[2], exp[1:0]);
        end
    endtask

    // Drive at negedge, let one posedge register, check at following negedge.
    task automatic beat(input logic v, input logic s, input logic odd,
                        input logic [7:0] c0, input logic [7:0] c1, input string tag);
        logic h0, h1;
        logic [2:0] exp;
        h0 = 1'b0; h1 = 1'b0;
        in_valid = v; in_sos = s; in_odd = odd; in_data = {c1, c0};
        if (s) ms = '0;
        if (v) begin
            ms = ref_step(ms, c0); h0 = ms[2];
            if (!odd) begin ms = ref_step(ms, c1); h1 = ms[2]; end
        end
        exp = {h0 | h1, h1, h0};
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    function automatic logic [7:0] pick_char();
        case ($urandom_range(0, 6))
            0, 1: return "a";
            2:    return "b";
            3:    return "3";
            4:    return "9";
            5:    return "b";
            default: return "x";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd9137));
        repeat (3) @(negedge clk);
        check(3'b000, "R1 reset outputs");
        rst_n = 1'b1;
        beat(1, 0, 0, "1", "b", "R1 empty state");
        // R2/R5: start in lane 1, digit and b in next beat -> lane 1 accepts
        beat(1, 0, 0, "x", "a", "R2 start lane1");
        beat(1, 0, 0, "7", "b", "R2 R5 cross-beat");
        // R6: both lanes accept via b loop
        beat(1, 0, 0, "a", "3", "R6 setup");
        beat(1, 0, 0, "b", "b", "R6 both lanes");
        // R4: digit loop
        beat(1, 0, 0, "a", "1", "R4 setup");
        beat(1, 0, 0, "2", "2", "R4 digits");
        beat(1, 0, 0, "9", "9", "R4 digits");
        beat(1, 0, 0, "b", "x", "R4 loop accept lane0");
        // R7/R8: idle cycles hold state, outputs quiet
        beat(1, 0, 0, "a", "5", "R8 setup");
        beat(0, 0, 0, "b", "b", "R7 idle quiet");
        beat(0, 0, 0, "x", "x", "R8 idle hold");
        beat(1, 0, 0, "b", "x", "R8 held state accepts");
        // R9: restart without data, then with data
        beat(1, 0, 0, "a", "5", "R9 setup");
        beat(0, 1, 0, "x", "x", "R9 clear idle");
        beat(1, 0, 0, "b", "b", "R9 cleared no match");
        beat(1, 0, 0, "a", "5", "R9 setup2");
        beat(1, 1, 0, "b", "b", "R9 restart with data");
        beat(1, 1, 0, "a", "5", "R9 restart fresh");
        beat(1, 0, 0, "b", "x", "R9 after restart");
        // R10: odd beat ignores lane 1
        beat(1, 0, 0, "a", "5", "R10 setup");
        beat(1, 0, 1, "5", "b", "R10 odd ignored");
        beat(1, 0, 0, "b", "x", "R10 state from lane0");
        beat(1, 0, 0, "a", "4", "R10 setup2");
        beat(1, 0, 1, "x", "b", "R10 odd break");
        beat(1, 0, 0, "b", "b", "R10 broken no match");
        // R3: class edges
        beat(1, 0, 0, "a", 8'h2F, "R3 below class");
        beat(1, 0, 0, "b", "x", "R3 below class");
        beat(1, 0, 0, "a", 8'h3A, "R3 above class");
        beat(1, 0, 0, "b", "x", "R3 above class");
        beat(1, 0, 0, "a", 8'h30, "R3 low edge");
        beat(1, 0, 0, 8'h39, "b", "R3 edge accept");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic v, s, o;
            v = ($urandom_range(0, 9) != 0);
            s = ($urandom_range(0, 29) == 0);
            o = ($urandom_range(0, 7) == 0);
            beat(v, s, o, pick_char(), pick_char(), "R5 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule